// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It combines two components and picks between them. The first component is per-branch. Part of the PC selects a stored history of that branch's recent outcomes, and that history selects a 3-bit saturating counter. The second component is path-based. A shift register holds the outcomes of the most recent branches across the program, and that register selects a 2-bit saturating counter. A third table of 2-bit counters is also addressed by the path history. It learns, for each path, which of the two components is more reliable, and the final prediction comes from the component it selects.

The lookup port is combinational. A fetch or decode stage presents a PC and receives the final direction together with both component directions. The pipeline keeps the two component directions with the branch. When the branch resolves, it returns them with the PC and the real outcome on the training port. Training addresses the counters with the histories as they stand before the outcome is appended. It then shifts the outcome into the path history and into the branch's own history entry. All training lands on the next clock edge.

Top module: `tourney_predictor`

## Requirements
- R1: The per-branch history table has 1024 entries of 10 bits each. It is addressed by PC bits [11:2], and the two low alignment bits are ignored.
- R2: The per-branch direction is the top bit of a 3-bit counter, which means taken when the counter is 4 or more. The counter is taken from a 1024-entry table addressed by the 10-bit history of the looked-up PC.
- R3: The path direction is the top bit of a 2-bit counter, which means taken when the counter is 2 or more. The counter is taken from a 4096-entry table addressed by the 12-bit path history.
- R4: A 4096-entry chooser table of 2-bit counters is addressed by the path history. A chooser value of 2 or more selects the path direction for `pred_taken`, and a value of 0 or 1 selects the per-branch direction. When both components agree, `pred_taken` equals their common value.
- R5: On a training cycle, both direction counters move one step toward the outcome: up when taken, down when not taken. They saturate at 0 and at their maximum (7 for 3-bit, 3 for 2-bit).
- R6: The chooser entry is trained only when `upd_local_pred` and `upd_global_pred` differ. It steps up (toward path) when the path direction matched the outcome, and down (toward per-branch) otherwise, with saturation.
- R7: Training addresses the counters with the pre-update histories. It then shifts `upd_taken` into bit 0 of the path history and into bit 0 of the history entry for `upd_pc`.
- R8: While `rst_n` is low, every counter and history is zero. All three outputs therefore read not-taken, and the chooser favours the per-branch component.
- R9: When `upd_valid` is low, no table or history changes, whatever the other training inputs carry.
- R10: The lookup is combinational and reads the state held before the current edge. A lookup in the same cycle as a training request sees the old state, and the training shows up from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | 32 | PC being looked up |
| pred_taken | output | 1 | Final predicted direction |
| pred_local | output | 1 | Per-branch component direction |
| pred_global | output | 1 | Path component direction |
| upd_valid | input | 1 | Training request |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_local_pred | input | 1 | Per-branch direction given at lookup |
| upd_global_pred | input | 1 | Path direction given at lookup |

## Verification
The first stimulus is one branch that is always taken. The histories fill with ones, both counters saturate, and further training must leave them at the top. This separates correct saturation from counter wrap-around. The second stimulus is a set of branches with short repeating outcome patterns (alternating, and three taken then one not taken). Only correct history shifting and indexing lets the per-branch table learn these patterns, so this exposes errors in shift direction, history width and PC bit selection. The third stimulus is random PCs with random outcomes, random component directions and idle cycles. It drives the chooser both ways, and it shows whether training leaks through when it is not requested or when the components agree.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Which component the chooser currently favours.
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

  localparam int unsigned PC_ALIGN_BITS = 2;

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] ctr_q [DEPTH];
  logic [CW-1:0] cur_val;
  logic [CW-1:0] nxt_val;

  always_comb begin
    cur_val = ctr_q[wr_idx];
    if (wr_up) nxt_val = (cur_val == CMAX) ? cur_val : cur_val + 1'b1;
    else       nxt_val = (cur_val == '0)   ? cur_val : cur_val - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= '0;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= nxt_val;
    end
  end

  // Top bit set means the counter sits in its upper half.
  assign rd_taken = ctr_q[rd_idx][CW-1];

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned HW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [HW-1:0]    rd_hist,
  input  logic [IDX_W-1:0] up_idx,
  output logic [HW-1:0]    up_hist,
  input  logic             up_en,
  input  logic             up_bit
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HW-1:0] hist_q [DEPTH];
  logic [HW-1:0] hist_nxt;

  always_comb hist_nxt = {up_hist[HW-2:0], up_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (up_en) begin
      hist_q[up_idx] <= hist_nxt;
    end
  end

  assign rd_hist = hist_q[rd_idx];
  assign up_hist = hist_q[up_idx];

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned LIDX_W  = 10,
  parameter int unsigned LHIST_W = 10,
  parameter int unsigned GHIST_W = 12,
  parameter int unsigned LCTR_W  = 3,
  parameter int unsigned GCTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local_pred,
  input  logic            upd_global_pred
);
  import tp_pkg::*;

  localparam int unsigned IDX_LO = PC_ALIGN_BITS;
  localparam int unsigned IDX_HI = PC_ALIGN_BITS + LIDX_W - 1;

  logic [LIDX_W-1:0]  pred_slot, upd_slot;
  logic [LHIST_W-1:0] pred_lhist, upd_lhist;
  logic [GHIST_W-1:0] ghist, ghist_nxt;
  logic               ghist_en;
  logic               chooser_en, chooser_up;
  logic               chooser_msb;
  pick_e              pick;

  assign pred_slot = pred_pc[IDX_HI:IDX_LO];
  assign upd_slot  = upd_pc[IDX_HI:IDX_LO];

  // Per-branch history storage
  tp_hist_table #(.IDX_W(LIDX_W), .HW(LHIST_W)) u_lhist (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (pred_slot),
    .rd_hist (pred_lhist),
    .up_idx  (upd_slot),
    .up_hist (upd_lhist),
    .up_en   (upd_valid),
    .up_bit  (upd_taken)
  );

  // Per-branch counters
  tp_ctr_table #(.IDX_W(LHIST_W), .CW(LCTR_W)) u_lctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_lhist),
    .rd_taken (pred_local),
    .wr_en    (upd_valid),
    .wr_idx   (upd_lhist),
    .wr_up    (upd_taken)
  );

  // Path counters
  tp_ctr_table #(.IDX_W(GHIST_W), .CW(GCTR_W)) u_gctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (ghist),
    .rd_taken (pred_global),
    .wr_en    (upd_valid),
    .wr_idx   (ghist),
    .wr_up    (upd_taken)
  );

  // Chooser: trained only on disagreement, toward the correct side
  assign chooser_en = upd_valid && (upd_local_pred != upd_global_pred);
  assign chooser_up = (upd_global_pred == upd_taken);

  tp_ctr_table #(.IDX_W(GHIST_W), .CW(GCTR_W)) u_chooser (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (ghist),
    .rd_taken (chooser_msb),
    .wr_en    (chooser_en),
    .wr_idx   (ghist),
    .wr_up    (chooser_up)
  );

  assign pick       = chooser_msb ? PICK_GLOBAL : PICK_LOCAL;
  assign pred_taken = (pick == PICK_GLOBAL) ? pred_global : pred_local;

  // Path history: next-state and register
  assign ghist_en = upd_valid;
  always_comb ghist_nxt = {ghist[GHIST_W-2:0], upd_taken};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghist <= '0;
    else if (ghist_en) ghist <= ghist_nxt;
  end

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned LHIST_W = 10,
  parameter int unsigned GHIST_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [PC_W-1:0]    upd_pc,
  input logic               pred_taken,
  input logic               pred_local,
  input logic               pred_global,
  input logic [GHIST_W-1:0] ghist,
  input logic [LHIST_W-1:0] upd_lhist
);

  // R7: path history takes the outcome in at bit 0
  a_r7_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)});

  // R7: per-branch history entry of a repeated PC shifts the outcome in
  a_r7_lhist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid ##1 $stable(upd_pc)) |->
      upd_lhist == {$past(upd_lhist[LHIST_W-2:0]), $past(upd_taken)});

  // R9: no training request leaves the path history alone
  a_r9_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  // R9: per-branch history of an unchanged PC holds without training
  a_r9_lhist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid ##1 $stable(upd_pc)) |-> $stable(upd_lhist));

  // R4: agreeing components decide the final direction
  a_r4_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local));

  // R8: reset holds everything at zero
  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (ghist == '0 && !pred_taken && !pred_local && !pred_global));

endmodule

bind tourney_predictor tp_checker #(
  .PC_W(PC_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)
) u_tp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .upd_taken   (upd_taken),
  .upd_pc      (upd_pc),
  .pred_taken  (pred_taken),
  .pred_local  (pred_local),
  .pred_global (pred_global),
  .ghist       (ghist),
  .upd_lhist   (upd_lhist)
);

// File: tb/tourney_predictor_test.sv
`timescale 1ns/1ps
module tourney_predictor_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pred_pc;
  logic        pred_taken, pred_local, pred_global;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken, upd_local_pred, upd_global_pred;

  always #5 clk = ~clk;

  tourney_predictor uut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_local_pred(upd_local_pred),
    .upd_global_pred(upd_global_pred)
  );

  // Behavioural reference state
  int lhist_m [1024];
  int lctr_m  [1024];
  int gctr_m  [4096];
  int ch_m    [4096];
  int gh_m;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic int slot_of(logic [31:0] pc);
    return (pc / 4) % 1024;
  endfunction

  function automatic bit m_local(logic [31:0] pc);
    return lctr_m[lhist_m[slot_of(pc)]] >= 4;
  endfunction

  function automatic bit m_global();
    return gctr_m[gh_m] >= 2;
  endfunction

  function automatic bit m_final(logic [31:0] pc);
    return (ch_m[gh_m] >= 2) ? m_global() : m_local(pc);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 1024; i++) begin lhist_m[i] = 0; lctr_m[i] = 0; end
    for (int i = 0; i < 4096; i++) begin gctr_m[i] = 0; ch_m[i] = 0; end
    gh_m = 0;
  endtask

  // Mirrors one clock edge of training
  task automatic m_train();
    int s, li;
    if (!upd_valid) return;
    s  = slot_of(upd_pc);
    li = lhist_m[s];
    if (upd_taken) begin
      if (lctr_m[li] < 7) lctr_m[li]++;
      if (gctr_m[gh_m] < 3) gctr_m[gh_m]++;
    end else begin
      if (lctr_m[li] > 0) lctr_m[li]--;
      if (gctr_m[gh_m] > 0) gctr_m[gh_m]--;
    end
    if (upd_local_pred != upd_global_pred) begin
      if (upd_global_pred == upd_taken) begin
        if (ch_m[gh_m] < 3) ch_m[gh_m]++;
      end else begin
        if (ch_m[gh_m] > 0) ch_m[gh_m]--;
      end
    end
    gh_m       = ((gh_m * 2) + upd_taken) % 4096;
    lhist_m[s] = ((li * 2) + upd_taken) % 1024;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pc=%h actual=%b expected=%b", req, pred_pc, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " R2 local"},  pred_local,  m_local(pred_pc));
    chk({tag, " R3 global"}, pred_global, m_global());
    chk({tag, " R4 final"},  pred_taken,  m_final(pred_pc));
  endtask

  // One cycle: set inputs, check after the settle, then mirror the edge.
  // The lookup uses the same PC as training so that R10 old-state reads are exercised.
  task automatic step(bit v, logic [31:0] pc, bit tk, bit use_model, bit lp, bit gp,
                      string tag);
    pred_pc   = pc;
    upd_valid = v;
    upd_pc    = pc;
    upd_taken = tk;
    upd_local_pred  = use_model ? m_local(pc) : lp;
    upd_global_pred = use_model ? m_global()  : gp;
    #1;
    compare_all(tag);              // R10: state before this edge
    @(posedge clk);
    m_train();
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    pred_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    upd_local_pred = 1'b0; upd_global_pred = 1'b0;
    m_reset();
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state, every output not taken
    chk("R8 reset local",  pred_local,  1'b0);
    chk("R8 reset global", pred_global, 1'b0);
    chk("R8 reset final",  pred_taken,  1'b0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R5: single always-taken branch drives counters to saturation
    for (int i = 0; i < 30; i++) step(1, 32'h0000_0400, 1, 1, 0, 0, "R5 sat-up");
    chk("R5 local saturated", pred_local, 1'b1);
    chk("R5 global saturated", pred_global, 1'b1);
    // one not-taken must not flip a saturated 3-bit counter in the per-branch path
    step(1, 32'h0000_0400, 0, 1, 0, 0, "R5 one-down");

    // R1: alignment bits ignored, and bit 12 aliasing onto the same slot
    step(0, 32'h0000_0403, 0, 0, 1, 1, "R1 align");
    step(0, 32'h0000_1400, 0, 0, 1, 1, "R1 alias");

    // R9: training inputs carry data but valid is low
    for (int i = 0; i < 8; i++) step(0, 32'h0000_0400, i[0], 0, i[1], i[2], "R9 idle");

    // R7/R2: periodic patterns at several branches
    for (int i = 0; i < 200; i++) begin
      step(1, 32'h0000_0800, i[0], 1, 0, 0, "R7 alternate");
      step(1, 32'h0000_0C04, (i % 4) != 3, 1, 0, 0, "R7 loop");
    end

    // R6: forced disagreements in both directions drive the chooser
    for (int i = 0; i < 40; i++) step(1, 32'h0000_2000, 1, 0, 0, 1, "R6 toward global");
    for (int i = 0; i < 40; i++) step(1, 32'h0000_2000, 0, 0, 0, 1, "R6 toward local");
    for (int i = 0; i < 20; i++) step(1, 32'h0000_2000, 1, 0, 1, 1, "R6 agree no train");

    // Random mix with idle cycles
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pc;
      pc = {$urandom_range(0, 15), 2'b00} << 4;
      pc[1:0] = $urandom_range(0, 3);
      step($urandom_range(0, 3) != 0, pc, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), "R10 random");
    end

    // R8: reset in the middle of a run clears everything again
    rst_n = 1'b0; #3;
    m_reset();
    chk("R8 midrun local",  pred_local,  1'b0);
    chk("R8 midrun global", pred_global, 1'b0);
    chk("R8 midrun final",  pred_taken,  1'b0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) step(1, 32'h0000_0400, 1, 1, 0, 0, "R8 after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule